// File: doc/BRIEF.md
# Register-Mapped Transaction Mailbox Bridge

This block sits on a local processor's register bus and lets that processor exchange 64-bit transaction words with a remote link partner. Each transaction word joins a 32-bit control word (flags and a target address) with a 32-bit payload. For an outbound transfer, the processor first writes the payload and then writes the control word. The control write places the combined word on an outbound valid/ready stream.

Inbound words arrive on a second valid/ready stream. A word with the read-response flag set finishes the outbound read that is waiting for it, and its payload is kept for the processor to read. Any other inbound word is treated as a request from the partner. The block latches it and stops taking inbound words until the processor has read the request's control word. A status register shows the busy condition and the three pending conditions. The processor answers a partner request by writing the response payload and then a control word that carries only the read-response flag.

Top module: `mbx_bridge`

## Requirements
- R1: A synchronous active-high reset sets `out_valid` to 0, `in_ready` to 1 and `bus_rdata` to 0. It also sets every status bit to 0 and every latched register to 0.
- R2: The register offsets on `bus_addr` are fixed. Offset 0 is the outbound payload on write and the inbound request payload on read. Offset 1 is the outbound control on write and the inbound request control on read. Offset 2 is the response payload and is read-only. Offset 3 is the status and is read-only. Writes to offsets 2 and 3 change nothing.
- R3: A control write made while no word is held raises `out_valid` in the next cycle. At that point `out_word` carries the written control in bits 63:32 and the last payload written to offset 0 in bits 31:0.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` does not change. After a cycle with both high, `out_valid` is 0.
- R5: Status bit 4 (busy) is 1 exactly while an outbound word is held (`out_valid` high). A control write made while busy is ignored: the held word does not change and the pending bits do not change.
- R6: Status bit 0 (read pending) is set when a launched control word has bit 29 (read request) set. Control bits 31 (read response), 30 (write request), 28 (half word) and 19:0 (address) pass through unchanged and do not set bit 0.
- R7: An accepted inbound word with bit 63 set (control bit 31, read response) does three things. It loads bits 31:0 into the response register, clears status bit 0 and sets status bit 2. Reading offset 2 clears bit 2. If a new bit-0 or bit-2 set event falls in the same cycle as a clear, the set wins.
- R8: An accepted inbound word with bit 63 clear is latched as a request and sets status bit 1. While bit 1 is set, `in_ready` is 0. Reading offset 0 returns the request payload. Reading offset 1 returns the request control and clears bit 1, so `in_ready` returns to 1 in the cycle after that read.
- R9: `bus_rdata` is registered. It shows the addressed register one cycle after `bus_rd` and keeps its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| out_valid | output | 1 | Outbound word valid |
| out_ready | input | 1 | Outbound word accepted by link |
| out_word | output | 64 | Outbound transaction word |
| in_valid | input | 1 | Inbound word valid |
| in_ready | output | 1 | Block can accept an inbound word |
| in_word | input | 64 | Inbound transaction word |

## Verification
The bench goes after the following corner cases, and each one names how a faulty design would show itself.

- **Control write while busy.** A design that does not ignore it would overwrite the held word, or would start a read it never launched.
- **Second request offered while one is latched.** A design that accepted it anyway would lose the first request.
- **Request accepted right after the control-register read frees the latch.** A design with an off-by-one in the release would stall here, or would accept the word one cycle early.
- **Response handling.** A response must clear read-pending and must not disturb the request path. A design that mixes the two flags would set the wrong status bit.

The bench also checks that writes to the read-only offsets change nothing, and that a reset in the middle of traffic drops a latched request.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_RESP = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;

  // positions counted down from the top of the control word
  localparam int FLAG_RESP_FROM_TOP  = 1;
  localparam int FLAG_RDREQ_FROM_TOP = 3;

  typedef struct packed {
    logic busy;
    logic resp_pend;
    logic req_pend;
    logic read_pend;
  } mbx_stat_t;
endpackage

// File: rtl/mbx_tx_stage.sv
module mbx_tx_stage #(
  parameter int XACT_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_req,
  input  logic [XACT_W-1:0] launch_word,
  output logic              launch_ok,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XACT_W-1:0] out_word
);
  logic              hold_q;
  logic [XACT_W-1:0] word_q;

  assign launch_ok = launch_req && !hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      word_q <= '0;
    end else if (launch_ok) begin
      hold_q <= 1'b1;
      word_q <= launch_word;
    end else if (hold_q && out_ready) begin
      hold_q <= 1'b0;
    end
  end

  assign out_valid = hold_q;
  assign out_word  = word_q;
endmodule

// File: rtl/mbx_rx_stage.sv
module mbx_rx_stage #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [2*WORD_W-1:0] in_word,
  output logic                in_ready,
  input  logic                ctrl_rd,
  input  logic                resp_rd,
  input  logic                rd_launch,
  output logic [WORD_W-1:0]   req_ctrl,
  output logic [WORD_W-1:0]   req_data,
  output logic [WORD_W-1:0]   resp_data,
  output logic                req_pend,
  output logic                resp_pend,
  output logic                read_pend
);
  localparam int RESP_BIT = 2*WORD_W - mbx_pkg::FLAG_RESP_FROM_TOP;

  logic req_q, resp_q, rdp_q;
  logic take, is_resp;

  assign take    = in_valid && !req_q;
  assign is_resp = in_word[RESP_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= 1'b0;
      resp_q    <= 1'b0;
      rdp_q     <= 1'b0;
      req_ctrl  <= '0;
      req_data  <= '0;
      resp_data <= '0;
    end else begin
      if (rd_launch)              rdp_q <= 1'b1;
      else if (take && is_resp)   rdp_q <= 1'b0;

      if (take && is_resp)        resp_q <= 1'b1;
      else if (resp_rd)           resp_q <= 1'b0;

      if (take && is_resp) resp_data <= in_word[WORD_W-1:0];

      if (take && !is_resp) begin
        req_q    <= 1'b1;
        req_ctrl <= in_word[2*WORD_W-1:WORD_W];
        req_data <= in_word[WORD_W-1:0];
      end else if (ctrl_rd) begin
        req_q <= 1'b0;
      end
    end
  end

  assign in_ready  = !req_q;
  assign req_pend  = req_q;
  assign resp_pend = resp_q;
  assign read_pend = rdp_q;
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [1:0]          bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*WORD_W-1:0] out_word,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2*WORD_W-1:0] in_word
);
  import mbx_pkg::*;

  localparam int XACT_W    = 2*WORD_W;
  localparam int RDREQ_BIT = WORD_W - FLAG_RDREQ_FROM_TOP;

  logic [WORD_W-1:0] data_q;
  logic              launch_req, launch_ok;
  logic [WORD_W-1:0] req_ctrl, req_data, resp_data;
  mbx_stat_t         stat;
  logic [WORD_W-1:0] stat_word;

  assign launch_req = bus_wr && (bus_addr == OFS_CTRL);

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else if (bus_wr && bus_addr == OFS_DATA) data_q <= bus_wdata;
  end

  mbx_tx_stage #(.XACT_W(XACT_W)) u_tx (
    .clk(clk), .rst(rst),
    .launch_req(launch_req), .launch_word({bus_wdata, data_q}),
    .launch_ok(launch_ok),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  mbx_rx_stage #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .ctrl_rd(bus_rd && bus_addr == OFS_CTRL),
    .resp_rd(bus_rd && bus_addr == OFS_RESP),
    .rd_launch(launch_ok && bus_wdata[RDREQ_BIT]),
    .req_ctrl(req_ctrl), .req_data(req_data), .resp_data(resp_data),
    .req_pend(stat.req_pend), .resp_pend(stat.resp_pend),
    .read_pend(stat.read_pend)
  );

  assign stat.busy = out_valid;
  assign stat_word = {{(WORD_W-5){1'b0}}, stat.busy, 1'b0,
                      stat.resp_pend, stat.req_pend, stat.read_pend};

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        OFS_DATA: bus_rdata <= req_data;
        OFS_CTRL: bus_rdata <= req_ctrl;
        OFS_RESP: bus_rdata <= resp_data;
        default:  bus_rdata <= stat_word;
      endcase
    end
  end
endmodule

module mbx_bridge_chk #(
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [1:0]          bus_addr,
  input logic [WORD_W-1:0]   bus_wdata,
  input logic [WORD_W-1:0]   bus_rdata,
  input logic                out_valid,
  input logic                out_ready,
  input logic [2*WORD_W-1:0] out_word,
  input logic                in_valid,
  input logic                in_ready,
  input logic [2*WORD_W-1:0] in_word,
  input logic                read_pend
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready && bus_rdata == '0));
  // R3
  launch_word_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd1 && !out_valid) |=>
      (out_valid && out_word[2*WORD_W-1:WORD_W] == $past(bus_wdata)));
  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
  // R5
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd1 && out_valid && out_ready) |=> !out_valid);
  // R7
  resp_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_word[2*WORD_W-1] &&
     !(bus_wr && bus_addr == 2'd1 && !out_valid && bus_wdata[WORD_W-3])) |=> !read_pend);
  // R8
  req_block_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_word[2*WORD_W-1]) |=> !in_ready);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind mbx_bridge mbx_bridge_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_valid(out_valid),
  .out_ready(out_ready), .out_word(out_word), .in_valid(in_valid),
  .in_ready(in_ready), .in_word(in_word), .read_pend(stat.read_pend)
);

// File: tb/test_mbx_bridge.sv
module test_mbx_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        out_valid, out_ready = 1'b0;
  logic [63:0] out_word;
  logic        in_valid = 1'b0, in_ready;
  logic [63:0] in_word = '0;

  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_bridge i_mbx_bridge (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word)
  );

  // behavioural reference model
  bit        m_ov, m_req, m_resp, m_rdp;
  bit [63:0] m_ow;
  bit [31:0] m_data, m_rctl, m_rdat, m_rsp, m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      m_ov = 0; m_req = 0; m_resp = 0; m_rdp = 0; m_ow = 0;
      m_data = 0; m_rctl = 0; m_rdat = 0; m_rsp = 0; m_rdata = 0;
    end else begin
      bit take, isr, go;
      take = in_valid && !m_req;
      isr  = in_word[63];
      go   = bus_wr && bus_addr == 2'd1 && !m_ov;
      if (bus_rd) begin
        if (bus_addr == 2'd0)      m_rdata = m_rdat;
        else if (bus_addr == 2'd1) m_rdata = m_rctl;
        else if (bus_addr == 2'd2) m_rdata = m_rsp;
        else m_rdata = {27'd0, m_ov, 1'b0, m_resp, m_req, m_rdp};
      end
      if (go && bus_wdata[29]) m_rdp = 1;
      else if (take && isr)    m_rdp = 0;
      if (take && isr) begin m_resp = 1; m_rsp = in_word[31:0]; end
      else if (bus_rd && bus_addr == 2'd2) m_resp = 0;
      if (take && !isr) begin
        m_req = 1; m_rctl = in_word[63:32]; m_rdat = in_word[31:0];
      end else if (bus_rd && bus_addr == 2'd1) m_req = 0;
      if (go) begin m_ov = 1; m_ow = {bus_wdata, m_data}; end
      else if (m_ov && out_ready) m_ov = 0;
      if (bus_wr && bus_addr == 2'd0) m_data = bus_wdata;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 out_valid", {63'd0, out_valid}, {63'd0, m_ov});
      chk("R3 out_word", out_word, m_ow);
      chk("R8 in_ready", {63'd0, in_ready}, {63'd0, !m_req});
      chk("R9 bus_rdata", {32'd0, bus_rdata}, {32'd0, m_rdata});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic send_in(input logic [63:0] w);
    @(negedge clk); in_valid = 1; in_word = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk("R1 in_ready after reset", {63'd0, in_ready}, 64'd1);
    rd(2'd3, v); chk("R1 status zero", {32'd0, v}, 64'd0);
    rd(2'd1, v); chk("R1 req ctrl zero", {32'd0, v}, 64'd0);
    rd(2'd2, v); chk("R1 resp zero", {32'd0, v}, 64'd0);

    // launch a write request, link stalled
    wr(2'd0, 32'hDEADBEEF);
    wr(2'd1, 32'h4001_2345);
    chk("R3 launched word", out_word, 64'h40012345_DEADBEEF);
    chk("R3 valid raised", {63'd0, out_valid}, 64'd1);
    rd(2'd3, v); chk("R5 busy set", {32'd0, v}, 64'h10);
    wr(2'd1, 32'h2000_0001);
    chk("R5 busy write ignored", out_word, 64'h40012345_DEADBEEF);
    rd(2'd3, v); chk("R5 no read pend from ignored write", {32'd0, v}, 64'h10);

    // read-only offsets
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd2, 32'h1111_2222);
    rd(2'd3, v); chk("R2 status write ignored", {32'd0, v}, 64'h10);
    rd(2'd2, v); chk("R2 resp write ignored", {32'd0, v}, 64'd0);

    // release the held word
    @(negedge clk); out_ready = 1;
    @(negedge clk); out_ready = 0;
    chk("R4 released", {63'd0, out_valid}, 64'd0);
    rd(2'd3, v); chk("R5 busy cleared", {32'd0, v}, 64'd0);

    // outbound read request
    out_ready = 1;
    wr(2'd0, 32'd0);
    wr(2'd1, 32'h2000_0100);
    chk("R6 read word", out_word, 64'h20000100_00000000);
    rd(2'd3, v); chk("R6 read pending set", {32'd0, v}, 64'h01);

    // inbound response
    send_in(64'h80000000_CAFEF00D);
    rd(2'd3, v); chk("R7 pend flip", {32'd0, v}, 64'h04);
    rd(2'd2, v); chk("R7 resp data", {32'd0, v}, 64'hCAFEF00D);
    rd(2'd3, v); chk("R7 resp pend cleared", {32'd0, v}, 64'd0);

    // inbound request, second one held off
    send_in(64'h40000ABC_12345678);
    rd(2'd3, v); chk("R8 req pending", {32'd0, v}, 64'h02);
    @(negedge clk); in_valid = 1; in_word = 64'h20000077_99990000;
    repeat (3) @(negedge clk);
    chk("R8 ready held low", {63'd0, in_ready}, 64'd0);
    rd(2'd0, v); chk("R8 req data", {32'd0, v}, 64'h12345678);
    rd(2'd1, v); chk("R8 req ctrl", {32'd0, v}, 64'h40000ABC);
    @(negedge clk); in_valid = 0;
    rd(2'd3, v); chk("R8 second request latched", {32'd0, v}, 64'h02);
    rd(2'd1, v); chk("R8 second ctrl", {32'd0, v}, 64'h20000077);

    // answer the request
    wr(2'd0, 32'h0000_55AA);
    wr(2'd1, 32'h8000_0000);
    chk("R6 response word", out_word, 64'h80000000_000055AA);
    rd(2'd3, v); chk("R6 no read pend from response", {32'd0, v}, 64'd0);

    // reset while a request is latched
    send_in(64'h40000001_00000002);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 reset drops request", {63'd0, in_ready}, 64'd1);
    rd(2'd3, v); chk("R1 status after mid reset", {32'd0, v}, 64'd0);
    rd(2'd0, v); chk("R1 req data cleared", {32'd0, v}, 64'd0);

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule